// File: doc/BRIEF.md
# Spin Lock Requester with Randomized Exponential Backoff

This block is a per-client hardware agent that obtains ownership of a single shared lock bit on behalf of a local client. The lock bit sits behind a simple memory-style request port that many agents share. When the client raises its acquire request, the agent polls the lock with ordinary reads until it sees the value free (0). Only then does it try the atomic swap-with-one. A swap that returns 0 means the agent now owns the lock, and it raises its grant to the client. A swap that returns 1 means another agent got there first.

After a lost swap the agent stays off the port for a pseudo-random number of cycles before it goes back to polling. The bound on that pause is a window that starts at a configured minimum for every new acquire request and doubles after each loss, up to a configured maximum. Each agent draws its random numbers from its own 16-bit LFSR with a per-instance seed, so agents that collide once are unlikely to collide again. The client gives the lock back with a release pulse, and the agent then issues a plain write of zero.

Top module: `spinlock_agent`

## Requirements
- R1: While reset is asserted and in the first cycle after it, grant is low and no memory request is presented.
- R2: Memory opcodes are read = 2'b00, swap-with-1 = 2'b01 and write-zero = 2'b10. After an acquire request the agent issues reads while they return 1. It issues a swap only in the cycle right after a read that returned 0.
- R3: A swap accepted with read data 0 raises grant in the next cycle.
- R4: A swap accepted with read data 1 leaves grant low, and no request is presented in the next cycle.
- R5: After a lost swap, the request line stays low for d+1 cycles before the next read, where d = r mod W. Here r is the LFSR value at the cycle the swap is accepted and W is the current window. The pause is therefore between 1 and W cycles.
- R6: The window is MIN_DLY for the first loss of each acquire request. It doubles after each loss while below MAX_DLY and then stays at MAX_DLY. Both parameters are powers of two.
- R7: A release pulse while granted drops grant in the next cycle and presents a write-zero request in that cycle. The agent goes idle once the write is accepted.
- R8: Any number of agents sharing one lock bit never hold grant at the same time, and every client that keeps requesting is eventually granted.
- R9: The random source is a 16-bit Galois LFSR that shifts right each cycle and XORs in 16'hB400 when the bit shifted out is 1. It starts from the SEED parameter and never reaches zero.
- R10: A release pulse while not granted is ignored, and no request is presented while idle.
- R11: A presented request keeps its opcode and stays presented until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acq_req | input | 1 | Client wants the lock (sampled while idle) |
| rel_req | input | 1 | Client gives the lock back (pulse, honoured while granted) |
| grant | output | 1 | The agent holds the lock |
| mem_valid | output | 1 | Memory request presented |
| mem_ready | input | 1 | Memory request accepted this cycle |
| mem_op | output | 2 | Opcode: 00 read, 01 swap-with-1, 10 write-zero |
| mem_rdata | input | 1 | Lock value before the accepted access |

## Verification
The bench builds three agents with MIN_DLY = 2 and MAX_DLY = 8, each with a distinct seed. With these values the window reaches its cap after only two lost swaps, so forced losses walk the window through growth, saturation and the restart on a new request within a short run. A reference LFSR seeded like the first agent lets the bench predict every backoff pause of that agent exactly. The three agents then contend on one lock while the shared port stalls periodically, which exercises real lost swaps and held requests.

// File: rtl/slk_pkg.sv
package slk_pkg;
  typedef enum logic [1:0] {
    MOP_READ  = 2'b00,
    MOP_SWAP  = 2'b01,
    MOP_CLEAR = 2'b10
  } mop_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LURK,
    ST_GRAB,
    ST_WAIT,
    ST_OWN,
    ST_DROP
  } agent_st_e;
endpackage

// File: rtl/slk_lfsr.sv
module slk_lfsr #(
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [15:0] rnd
);
  localparam logic [15:0] TAPS = 16'hB400;

  logic [15:0] s_q, s_d;

  always_comb begin
    s_d = s_q >> 1;
    if (s_q[0]) s_d = s_d ^ TAPS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s_q <= SEED;
    else        s_q <= s_d;
  end

  assign rnd = s_q;

  // R9
  lfsr_live_chk: assert property (@(posedge clk) disable iff (!rst_n) s_q != 16'h0000);
endmodule

// File: rtl/slk_window.sv
module slk_window #(
  parameter int MIN_DLY = 2,
  parameter int MAX_DLY = 16,
  parameter int WW      = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          grow,
  output logic [WW-1:0] win
);
  localparam logic [WW-1:0] WMIN = WW'(MIN_DLY);
  localparam logic [WW-1:0] WMAX = WW'(MAX_DLY);

  logic [WW-1:0] w_q, w_d;
  logic          w_en;

  always_comb begin
    w_d  = w_q;
    w_en = restart | grow;
    if (restart)             w_d = WMIN;
    else if (w_q < WMAX)     w_d = w_q << 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    w_q <= WMIN;
    else if (w_en) w_q <= w_d;
  end

  assign win = w_q;

  // R6
  win_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (w_q >= WMIN) && (w_q <= WMAX) && ($countones(w_q) == 1));
  // R6
  win_double_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grow && !restart && (w_q < WMAX)) |=> (w_q == ($past(w_q) << 1)));
endmodule

// File: rtl/slk_delay.sv
module slk_delay #(
  parameter int CW = 4,
  parameter int WW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          run,
  input  logic [CW-1:0] rnd,
  input  logic [WW-1:0] win,
  output logic          done
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic [WW-1:0] win_m1;
  logic          cnt_en;

  assign win_m1 = win - WW'(1);

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (load) begin
      cnt_d  = rnd & win_m1[CW-1:0];
      cnt_en = 1'b1;
    end else if (run && (cnt_q != '0)) begin
      cnt_d  = cnt_q - CW'(1);
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

  // R5
  dly_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, cnt_q} < win);
endmodule

// File: rtl/spinlock_agent.sv
module spinlock_agent
  import slk_pkg::*;
#(
  parameter int          MIN_DLY = 2,
  parameter int          MAX_DLY = 16,
  parameter logic [15:0] SEED    = 16'hACE1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acq_req,
  input  logic       rel_req,
  output logic       grant,
  output logic       mem_valid,
  input  logic       mem_ready,
  output logic [1:0] mem_op,
  input  logic       mem_rdata
);
  localparam int CW = $clog2(MAX_DLY);
  localparam int WW = CW + 1;

  agent_st_e     st_q, st_d;
  mop_e          op_sel;
  logic          hs;
  logic          win_restart, win_grow, dly_load, dly_run, dly_done;
  logic [15:0]   rnd;
  logic [WW-1:0] win;

  assign hs = mem_valid & mem_ready;

  always_comb begin
    st_d        = st_q;
    op_sel      = MOP_READ;
    mem_valid   = 1'b0;
    win_restart = 1'b0;
    win_grow    = 1'b0;
    dly_load    = 1'b0;
    dly_run     = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (acq_req) begin
          win_restart = 1'b1;
          st_d        = ST_LURK;
        end
      end
      ST_LURK: begin
        mem_valid = 1'b1;
        if (hs && !mem_rdata) st_d = ST_GRAB;
      end
      ST_GRAB: begin
        mem_valid = 1'b1;
        op_sel    = MOP_SWAP;
        if (hs) begin
          if (mem_rdata) begin
            dly_load = 1'b1;
            win_grow = 1'b1;
            st_d     = ST_WAIT;
          end else begin
            st_d     = ST_OWN;
          end
        end
      end
      ST_WAIT: begin
        dly_run = 1'b1;
        if (dly_done) st_d = ST_LURK;
      end
      ST_OWN: begin
        if (rel_req) st_d = ST_DROP;
      end
      ST_DROP: begin
        mem_valid = 1'b1;
        op_sel    = MOP_CLEAR;
        if (hs) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign grant  = (st_q == ST_OWN);
  assign mem_op = op_sel;

  slk_lfsr #(.SEED(SEED)) u_rnd (
    .clk (clk),
    .rst_n (rst_n),
    .rnd (rnd)
  );

  slk_window #(.MIN_DLY(MIN_DLY), .MAX_DLY(MAX_DLY), .WW(WW)) u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (win_restart),
    .grow    (win_grow),
    .win     (win)
  );

  slk_delay #(.CW(CW), .WW(WW)) u_dly (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (dly_load),
    .run   (dly_run),
    .rnd   (rnd[CW-1:0]),
    .win   (win),
    .done  (dly_done)
  );

  // R2
  swap_after_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && (mem_op == 2'b00) && !mem_rdata) |=> (mem_valid && (mem_op == 2'b01)));
  // R3
  win_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && (mem_op == 2'b01) && !mem_rdata) |=> grant);
  // R4
  loss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && (mem_op == 2'b01) && mem_rdata) |=> (!grant && !mem_valid));
  // R7
  release_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && rel_req) |=> (!grant && mem_valid && (mem_op == 2'b10)));
  // R8
  grant_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> !mem_valid);
  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_op)));
endmodule

// File: tb/spinlock_agent_test.sv
module spinlock_agent_test;
  localparam int          NAG   = 3;
  localparam int          MIN   = 2;
  localparam int          MAX   = 8;
  localparam logic [15:0] SEED0 = 16'hACE1;
  localparam logic [1:0]  OP_RD = 2'b00;
  localparam logic [1:0]  OP_SW = 2'b01;
  localparam logic [1:0]  OP_WR = 2'b10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       acq [NAG];
  logic       rel [NAG];
  logic       gnt [NAG];
  logic       mv  [NAG];
  logic       mr  [NAG];
  logic [1:0] mop [NAG];

  logic lk_q;
  logic ext_hold = 1'b0;
  logic lkv;
  logic stall_en = 1'b0;
  int   sab_target = 0;
  int   sab_done;
  bit   sab_pend;
  int   rr;
  int   cyc;

  assign lkv = lk_q | ext_hold;

  for (genvar i = 0; i < NAG; i++) begin : g_ag
    spinlock_agent #(
      .MIN_DLY(MIN), .MAX_DLY(MAX), .SEED(16'(SEED0 + 16'h1357 * i))
    ) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .acq_req   (acq[i]),
      .rel_req   (rel[i]),
      .grant     (gnt[i]),
      .mem_valid (mv[i]),
      .mem_ready (mr[i]),
      .mem_op    (mop[i]),
      .mem_rdata (lkv)
    );
  end

  // shared lock register with a rotating single-winner port
  always_comb begin
    bit taken;
    taken = 1'b0;
    for (int k = 0; k < NAG; k++) mr[k] = 1'b0;
    if (!(stall_en && (cyc % 7 == 3))) begin
      for (int k = 0; k < NAG; k++) begin
        int j;
        j = (rr + k) % NAG;
        if (mv[j] && !taken) begin
          mr[j] = 1'b1;
          taken = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_q     <= 1'b0;
      rr       <= 0;
      cyc      <= 0;
      sab_done <= 0;
      sab_pend <= 1'b0;
    end else begin
      cyc <= cyc + 1;
      rr  <= (rr + 1) % NAG;
      for (int k = 0; k < NAG; k++) begin
        if (mr[k]) begin
          if (mop[k] == OP_SW) lk_q <= 1'b1;
          if (mop[k] == OP_WR) lk_q <= 1'b0;
        end
      end
      // a phantom owner steals the lock between agent 0's read and swap
      if (mr[0] && mop[0] == OP_RD && !lkv && sab_done < sab_target) begin
        lk_q     <= 1'b1;
        sab_pend <= 1'b1;
        sab_done <= sab_done + 1;
      end
      if (mr[0] && mop[0] == OP_SW && sab_pend) begin
        lk_q     <= 1'b0;
        sab_pend <= 1'b0;
      end
    end
  end

  // reference random source for agent 0
  logic [15:0] ref_rnd;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_rnd <= SEED0;
    else        ref_rnd <= {1'b0, ref_rnd[15:1]} ^ (ref_rnd[0] ? 16'hB400 : 16'h0000);
  end

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic [1:0] op;
    logic       chk_rd;
    logic       rd;
  } exp_t;

  exp_t sbq[$];
  bit   sb_on = 1'b0;

  bit   last_rd0, exp_gnt, exp_loss, in_gap, pend_v;
  logic [1:0] pend_op;
  int   gap, exp_gap;
  int   mwin = MIN;
  int   rd_cnt0 = 0;
  int   ext_sw = 0;
  int   gcount [NAG];
  bit   gprev [NAG];

  // monitor: pops expected accesses and checks timing at the ports
  always @(negedge clk) begin
    if (rst_n) begin
      int held;
      held = 0;
      for (int k = 0; k < NAG; k++) begin
        held += int'(gnt[k]);
        if (gnt[k] && !gprev[k]) gcount[k]++;
        gprev[k] = gnt[k];
      end
      chk(held <= 1, "R8", "agents granted at once", held, 1);

      if (pend_v) chk(mv[0] && mop[0] == pend_op, "R11", "held request opcode",
                      int'(mop[0]), int'(pend_op));
      pend_v  = mv[0] && !mr[0];
      pend_op = mop[0];

      if (exp_gnt) begin
        chk(gnt[0], "R3", "grant after winning swap", int'(gnt[0]), 1);
        exp_gnt = 1'b0;
      end
      if (exp_loss) begin
        chk(!gnt[0] && !mv[0], "R4", "grant|request after lost swap",
            int'(gnt[0]) + int'(mv[0]), 0);
        exp_loss = 1'b0;
      end
      if (in_gap) begin
        if (mv[0]) begin
          chk(gap >= 1 && gap <= mwin, "R5/R6", "pause within window", gap, mwin);
          chk(gap == exp_gap, "R9", "pause from random source", gap, exp_gap);
          mwin   = (mwin * 2 > MAX) ? MAX : mwin * 2;
          in_gap = 1'b0;
        end else begin
          gap++;
        end
      end

      if (mv[0] && mr[0]) begin
        if (mop[0] == OP_RD) rd_cnt0++;
        if (mop[0] == OP_SW) begin
          chk(last_rd0, "R2", "swap follows a free read", int'(last_rd0), 1);
          if (ext_hold) ext_sw++;
          if (!lkv) begin
            exp_gnt = 1'b1;
          end else begin
            exp_loss = 1'b1;
            in_gap   = 1'b1;
            gap      = 0;
            exp_gap  = int'(ref_rnd & 16'(mwin - 1)) + 1;
          end
        end
        if (mop[0] == OP_WR) mwin = MIN;
        last_rd0 = (mop[0] == OP_RD) && !lkv;
        if (sb_on) begin
          if (sbq.size() == 0) begin
            chk(1'b0, "R2", "unexpected access opcode", int'(mop[0]), -1);
          end else begin
            exp_t e;
            e = sbq.pop_front();
            chk(mop[0] == e.op, "R2", "access opcode", int'(mop[0]), int'(e.op));
            if (e.chk_rd) chk(lkv == e.rd, "R2", "lock value seen", int'(lkv), int'(e.rd));
          end
        end
      end
    end
  end

  // driver: pushes the expected accesses of one acquire of agent 0
  task automatic acquire0(input int nsab);
    if (sb_on) begin
      for (int s = 0; s < nsab; s++) begin
        sbq.push_back('{op: OP_RD, chk_rd: 1'b1, rd: 1'b0});
        sbq.push_back('{op: OP_SW, chk_rd: 1'b1, rd: 1'b1});
      end
      sbq.push_back('{op: OP_RD, chk_rd: 1'b1, rd: 1'b0});
      sbq.push_back('{op: OP_SW, chk_rd: 1'b1, rd: 1'b0});
    end
    sab_target = sab_done + nsab;
    @(negedge clk);
    acq[0] = 1'b1;
    for (int t = 0; t < 3000 && !gnt[0]; t++) @(negedge clk);
    chk(gnt[0], "R3", "agent 0 granted", int'(gnt[0]), 1);
    acq[0] = 1'b0;
  endtask

  task automatic release0();
    @(negedge clk);
    rel[0] = 1'b1;
    if (sb_on) sbq.push_back('{op: OP_WR, chk_rd: 1'b0, rd: 1'b0});
    @(negedge clk);
    rel[0] = 1'b0;
    chk(!gnt[0], "R7", "grant after release", int'(gnt[0]), 0);
    chk(mv[0] && mop[0] == OP_WR, "R7", "write-zero presented", int'(mop[0]), int'(OP_WR));
    for (int t = 0; t < 50 && mv[0]; t++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic client(input int id);
    repeat (6) begin
      @(negedge clk);
      acq[id] = 1'b1;
      for (int t = 0; t < 5000 && !gnt[id]; t++) @(negedge clk);
      acq[id] = 1'b0;
      repeat (2 + id) @(negedge clk);
      rel[id] = 1'b1;
      @(negedge clk);
      rel[id] = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  initial begin
    for (int k = 0; k < NAG; k++) begin
      acq[k] = 1'b0;
      rel[k] = 1'b0;
      gcount[k] = 0;
      gprev[k] = 1'b0;
    end
    repeat (3) @(negedge clk);
    for (int k = 0; k < NAG; k++)
      chk(!gnt[k] && !mv[k], "R1", "grant|request in reset", int'(gnt[k]) + int'(mv[k]), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < NAG; k++)
      chk(!gnt[k] && !mv[k], "R1", "grant|request after reset", int'(gnt[k]) + int'(mv[k]), 0);
    stall_en = 1'b1;

    // R10: stray release while idle
    rel[0] = 1'b1;
    @(negedge clk);
    rel[0] = 1'b0;
    repeat (6) begin
      @(negedge clk);
      chk(!mv[0] && !gnt[0], "R10", "idle after stray release", int'(mv[0]) + int'(gnt[0]), 0);
    end

    // clean acquire, then forced losses walking the window to its cap
    sb_on = 1'b1;
    acquire0(0);
    release0();
    acquire0(5);
    release0();
    // R6: new request restarts the window
    acquire0(2);
    release0();
    chk(sbq.size() == 0, "R2", "expected accesses left over", sbq.size(), 0);
    sb_on = 1'b0;

    // R2: lurking while the lock is held by someone else
    begin
      int base;
      base = rd_cnt0;
      @(negedge clk);
      ext_hold = 1'b1;
      acq[0] = 1'b1;
      repeat (40) @(negedge clk);
      chk(rd_cnt0 - base >= 5, "R2", "reads while lock taken", rd_cnt0 - base, 5);
      chk(ext_sw == 0, "R2", "swaps while lock taken", ext_sw, 0);
      chk(!gnt[0], "R2", "grant while lock taken", int'(gnt[0]), 0);
      ext_hold = 1'b0;
      for (int t = 0; t < 200 && !gnt[0]; t++) @(negedge clk);
      chk(gnt[0], "R2", "grant once lock freed", int'(gnt[0]), 1);
      acq[0] = 1'b0;
      release0();
    end

    // R8: three agents contend on one lock
    begin
      int base [NAG];
      for (int k = 0; k < NAG; k++) base[k] = gcount[k];
      for (int a = 0; a < NAG; a++) begin
        automatic int id = a;
        fork
          client(id);
        join_none
      end
      wait fork;
      repeat (10) @(negedge clk);
      for (int k = 0; k < NAG; k++)
        chk(gcount[k] - base[k] == 6, "R8", "grants per agent", gcount[k] - base[k], 6);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule